// File: doc/BRIEF.md
# Serial Receive Queue with Fill Trigger and Idle Timeout

This block buffers bytes coming out of a serial deserializer until software, or a DMA engine, pops them. Storage is a circular array of sixteen bytes. A read index and a write index both wrap at the depth, and a separate occupancy counter tracks the fill. The oldest byte is always visible on the head output. A pop strobe advances past it.

A receive-ready flag and an interrupt request tell the consumer that data is waiting. There are two ways these are raised. The first is a push that brings the occupancy up to a selectable trigger level of 1, 4, 8 or 14. The second is an idle timer, which fires after fifteen elementary time units with no new byte while the occupancy is still below the trigger level. The timer lets a short burst be collected without waiting for the trigger to fill. The unit tick comes from the baud generator. A one-cycle flush pulse empties the queue.

Top module: `rxq_fifo`

## Requirements
- R1: After reset the count is 0, the head output is 0, and both the ready flag and the interrupt request are low.
- R2: Bytes leave in the order they arrived. The head output shows the oldest byte, and the count equals pushes accepted minus pops performed. Both indices wrap after 16 entries.
- R3: A push while the count is 16, with no pop in the same cycle, is dropped. The count stays at 16 and the head is unchanged.
- R4: A push while the receive-enable input is low is dropped.
- R5: The trigger select encodes the level as follows: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14.
- R6: A push that leaves the count at or above the trigger level sets the ready flag in the next cycle. If the interrupt enable is high, it also raises the interrupt request and stops the idle timer.
- R7: A push that leaves the count below the trigger level restarts the idle timer. The timer counts ticks at the clock edges that follow the push. On the 15th tick without a further push, the ready flag is set, and the interrupt request is raised if it is enabled.
- R8: A pop that leaves the count below the trigger level clears the ready flag and the interrupt request. An expiry of the idle timer in the same cycle takes precedence and sets the flag.
- R9: A pop while the queue is empty changes nothing, and the head output reads 0 while the count is 0.
- R10: A push and a pop in the same cycle leave the count unchanged, even when the queue is full, and the arrival order is kept.
- R11: A flush pulse takes precedence over a push and a pop in the same cycle. It clears the count, the indices, the ready flag and the interrupt request, and it cancels a running idle timer.
- R12: The interrupt request is high only in the cycle after one in which the interrupt enable was high. Dropping the enable clears the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Received byte strobe |
| push_data_i | input | 8 | Received byte |
| pop_i | input | 1 | Consume the head byte |
| flush_i | input | 1 | Empty the queue |
| trig_sel_i | input | 2 | Trigger level select (R5 encoding) |
| rx_en_i | input | 1 | Receive enable |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| etu_tick_i | input | 1 | One elementary time unit has elapsed |
| head_o | output | 8 | Oldest byte, 0 when empty |
| count_o | output | 5 | Number of stored bytes |
| full_flag_o | output | 1 | Receive-ready flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
A push and a pop can fall in the same cycle. So can a timer expiry and a pop that drops the count below the trigger level, or a flush together with any of these. The random phase draws push, pop, tick and rare flush strobes independently each cycle, so these collisions occur often. Directed steps also force a push and a pop together on a full queue. Each cycle's outputs are compared with a bench model that applies the stated priorities: flush over everything, and a timer expiry over a pop clear.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        TRIG_1  = 2'd0,
        TRIG_4  = 2'd1,
        TRIG_8  = 2'd2,
        TRIG_14 = 2'd3
    } trig_sel_e;

endpackage

// File: rtl/rxq_trig_decode.sv
module rxq_trig_decode #(
    parameter int CW = 5
) (
    input  logic [1:0]    sel_i,
    output logic [CW-1:0] level_o
);
    import rxq_pkg::*;

    always_comb begin
        case (trig_sel_e'(sel_i))
            TRIG_1:  level_o = CW'(1);
            TRIG_4:  level_o = CW'(4);
            TRIG_8:  level_o = CW'(8);
            TRIG_14: level_o = CW'(14);
            default: level_o = CW'(1);
        endcase
    end
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int LIMIT = 15,
    localparam int TW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic cancel_i,
    input  logic tick_i,
    output logic expire_o
);
    typedef struct packed {
        logic          active;
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d    = tmr_q;
        expire_o = 1'b0;
        if (restart_i) begin
            tmr_d.active = 1'b1;
            tmr_d.cnt    = TW'(LIMIT);
        end else if (cancel_i) begin
            tmr_d.active = 1'b0;
        end else if (tmr_q.active && tick_i) begin
            if (tmr_q.cnt == TW'(1)) begin
                expire_o     = 1'b1;
                tmr_d.active = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [PW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [PW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
    parameter int DEPTH   = 16,
    parameter int DW      = 8,
    parameter int TMO_ETU = 15,
    localparam int PW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    input  logic          flush_i,
    input  logic [1:0]    trig_sel_i,
    input  logic          rx_en_i,
    input  logic          rx_irq_en_i,
    input  logic          etu_tick_i,
    output logic [DW-1:0] head_o,
    output logic [CW-1:0] count_o,
    output logic          full_flag_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          flag;
        logic          irq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [CW-1:0] level;
    logic [CW-1:0] cnt_nx;
    logic          pop_ok, push_ok, reach;
    logic          tmr_restart, tmr_cancel, tmr_expire;
    logic          set_evt;
    logic [DW-1:0] rdata;

    rxq_trig_decode #(.CW(CW)) u_trig (
        .sel_i   (trig_sel_i),
        .level_o (level)
    );

    rxq_timer #(.LIMIT(TMO_ETU)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (tmr_restart),
        .cancel_i  (tmr_cancel),
        .tick_i    (etu_tick_i),
        .expire_o  (tmr_expire)
    );

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .we_i    (push_ok && !flush_i),
        .waddr_i (ctl_q.wr),
        .wdata_i (push_data_i),
        .raddr_i (ctl_q.rd),
        .rdata_o (rdata)
    );

    always_comb begin
        pop_ok  = pop_i && (ctl_q.cnt != '0);
        push_ok = push_i && rx_en_i && ((ctl_q.cnt != CW'(DEPTH)) || pop_ok);
        cnt_nx  = ctl_q.cnt + CW'(push_ok) - CW'(pop_ok);
        reach   = push_ok && (cnt_nx >= level);

        tmr_restart = !flush_i && push_ok && !reach;
        tmr_cancel  = flush_i || (reach && rx_irq_en_i);

        ctl_d   = ctl_q;
        set_evt = 1'b0;
        if (flush_i) begin
            ctl_d = '0;
        end else begin
            ctl_d.cnt = cnt_nx;
            if (push_ok) ctl_d.wr = ctl_q.wr + PW'(1);
            if (pop_ok)  ctl_d.rd = ctl_q.rd + PW'(1);
            if (reach) begin
                ctl_d.flag = 1'b1;
            end else if (pop_ok && (cnt_nx < level)) begin
                ctl_d.flag = 1'b0;
            end
            if (tmr_expire) ctl_d.flag = 1'b1;
            set_evt   = reach || tmr_expire;
            ctl_d.irq = rx_irq_en_i && (set_evt || (ctl_q.irq && ctl_d.flag));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign head_o      = (ctl_q.cnt == '0) ? '0 : rdata;
    assign count_o     = ctl_q.cnt;
    assign full_flag_o = ctl_q.flag;
    assign irq_o       = ctl_q.irq;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_i,
    input logic          pop_i,
    input logic          flush_i,
    input logic          rx_en_i,
    input logic          rx_irq_en_i,
    input logic [CW-1:0] count_o,
    input logic          full_flag_o,
    input logic          irq_o
);
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CW'(DEPTH) && push_i && !pop_i && !flush_i) |=> (count_o == CW'(DEPTH)));

    assert_rx_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en_i && !pop_i && !flush_i) |=> $stable(count_o));

    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0 && pop_i && !push_i && !flush_i) |=> (count_o == '0));

    assert_push_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && rx_en_i && count_o != '0 && !flush_i) |=> $stable(count_o));

    assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (count_o == '0 && !full_flag_o && !irq_o));

    assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_irq_en_i |=> !irq_o);

    assert_irq_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> full_flag_o);
endmodule

bind rxq_fifo rxq_checker #(.DEPTH(DEPTH)) u_rxq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .flush_i     (flush_i),
    .rx_en_i     (rx_en_i),
    .rx_irq_en_i (rx_irq_en_i),
    .count_o     (count_o),
    .full_flag_o (full_flag_o),
    .irq_o       (irq_o)
);

// File: tb/rxq_fifo_test.sv
module rxq_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_i = 1'b0;
    logic [7:0] push_data_i = '0;
    logic       pop_i = 1'b0;
    logic       flush_i = 1'b0;
    logic [1:0] trig_sel_i = '0;
    logic       rx_en_i = 1'b0;
    logic       rx_irq_en_i = 1'b0;
    logic       etu_tick_i = 1'b0;
    logic [7:0] head_o;
    logic [4:0] count_o;
    logic       full_flag_o;
    logic       irq_o;

    int n_chk = 0;
    int n_err = 0;

    int m_q [16];
    int m_rd = 0, m_wr = 0, m_cnt = 0, m_tcnt = 0;
    bit m_flag = 0, m_irq = 0, m_tact = 0;

    always #5 clk = ~clk;

    rxq_fifo uut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
        .pop_i(pop_i), .flush_i(flush_i), .trig_sel_i(trig_sel_i), .rx_en_i(rx_en_i),
        .rx_irq_en_i(rx_irq_en_i), .etu_tick_i(etu_tick_i), .head_o(head_o),
        .count_o(count_o), .full_flag_o(full_flag_o), .irq_o(irq_o)
    );

    function automatic int trig_level(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int m_head();
        return (m_cnt == 0) ? 0 : m_q[m_rd];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_update();
        bit pope, pusha, reach, restart, cancel, fire;
        int ncnt, trg;
        if (flush_i) begin
            m_cnt = 0; m_rd = 0; m_wr = 0; m_flag = 0; m_irq = 0; m_tact = 0;
            return;
        end
        trg     = trig_level(trig_sel_i);
        pope    = pop_i && m_cnt > 0;
        pusha   = push_i && rx_en_i && (m_cnt < 16 || pope);
        ncnt    = m_cnt + int'(pusha) - int'(pope);
        reach   = pusha && ncnt >= trg;
        restart = pusha && !reach;
        cancel  = reach && rx_irq_en_i;
        fire    = m_tact && etu_tick_i && m_tcnt == 1 && !restart && !cancel;
        if (restart) begin m_tact = 1; m_tcnt = 15; end
        else if (cancel) m_tact = 0;
        else if (m_tact && etu_tick_i) begin
            if (m_tcnt == 1) m_tact = 0; else m_tcnt--;
        end
        if (reach) m_flag = 1;
        else if (pope && ncnt < trg) m_flag = 0;
        if (fire) m_flag = 1;
        m_irq = rx_irq_en_i && (reach || fire || (m_irq && m_flag));
        if (pusha) begin m_q[m_wr] = push_data_i; m_wr = (m_wr + 1) % 16; end
        if (pope) m_rd = (m_rd + 1) % 16;
        m_cnt = ncnt;
    endtask

    task automatic step(input bit p, input int d, input bit po, input bit fl, input bit tk);
        @(negedge clk);
        push_i = p; push_data_i = 8'(d); pop_i = po; flush_i = fl; etu_tick_i = tk;
        model_update();
        @(posedge clk);
        #1;
        check(count_o == 5'(m_cnt), "R2 count", count_o, m_cnt);
        check(head_o == 8'(m_head()), "R2 head", head_o, m_head());
        check(full_flag_o == m_flag, "R6/R7/R8 flag", full_flag_o, m_flag);
        check(irq_o == m_irq, "R12 irq", irq_o, m_irq);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(count_o == 0 && head_o == 0, "R1 reset count/head", count_o, 0);
        check(!full_flag_o && !irq_o, "R1 reset flag/irq", full_flag_o, 0);
        @(negedge clk);
        rst_n = 1'b1; rx_en_i = 1'b1; rx_irq_en_i = 1'b1; trig_sel_i = 2'd0;

        // trigger 1: one push raises flag and irq, pop clears
        step(1, 8'hA5, 0, 0, 0);
        check(full_flag_o && irq_o, "R6 level-1 push raises flag+irq", irq_o, 1);
        step(0, 0, 1, 0, 0);
        check(!full_flag_o && !irq_o, "R8 pop below trigger clears", full_flag_o, 0);
        step(0, 0, 1, 0, 0);
        check(count_o == 0 && head_o == 0, "R9 empty pop", head_o, 0);

        // trigger 4
        trig_sel_i = 2'd1;
        for (int i = 0; i < 3; i++) step(1, i + 1, 0, 0, 0);
        check(!full_flag_o, "R5 three below level 4", full_flag_o, 0);
        step(1, 4, 0, 0, 0);
        check(full_flag_o, "R5 fourth reaches level 4", full_flag_o, 1);
        step(0, 0, 0, 1, 0);
        check(count_o == 0 && !full_flag_o, "R11 flush empties", count_o, 0);

        // idle timeout at level 14
        trig_sel_i = 2'd3;
        step(1, 8'h3C, 0, 0, 0);
        for (int i = 0; i < 14; i++) step(0, 0, 0, 0, 1);
        check(!full_flag_o, "R7 no expiry after 14 ticks", full_flag_o, 0);
        step(0, 0, 0, 0, 1);
        check(full_flag_o && irq_o, "R7 expiry on 15th tick", full_flag_o, 1);
        step(0, 0, 0, 1, 0);

        // flush cancels timer
        step(1, 8'h11, 0, 0, 0);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1);
        step(0, 0, 0, 1, 0);
        for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1);
        check(!full_flag_o && !irq_o, "R11 flush cancels timeout", full_flag_o, 0);

        // fill, overflow, simultaneous push/pop when full
        for (int i = 0; i < 16; i++) step(1, i + 16, 0, 0, 0);
        step(1, 8'hEE, 0, 0, 0);
        check(count_o == 16 && head_o == 16, "R3 overflow dropped", count_o, 16);
        step(1, 8'h77, 1, 0, 0);
        check(count_o == 16 && head_o == 17, "R10 push+pop when full", head_o, 17);
        for (int i = 0; i < 15; i++) begin
            check(head_o == 8'(i + 17), "R2 order after wrap", head_o, i + 17);
            step(0, 0, 1, 0, 0);
        end
        check(head_o == 8'h77, "R10 order kept", head_o, 8'h77);
        step(0, 0, 1, 0, 0);

        // receive disabled
        rx_en_i = 1'b0;
        step(1, 8'h55, 0, 0, 0);
        check(count_o == 0, "R4 push ignored when disabled", count_o, 0);
        rx_en_i = 1'b1;

        // interrupt disabled
        rx_irq_en_i = 1'b0; trig_sel_i = 2'd0;
        step(1, 8'h42, 0, 0, 0);
        check(full_flag_o && !irq_o, "R12 flag without irq", irq_o, 0);
        rx_irq_en_i = 1'b1;
        step(0, 0, 0, 0, 0);
        check(!irq_o, "R12 no irq without event", irq_o, 0);
        step(1, 8'h43, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        rx_irq_en_i = 1'b0;
        step(0, 0, 0, 0, 0);
        check(!irq_o, "R12 enable drop clears irq", irq_o, 0);
        step(0, 0, 0, 1, 0);

        // random phase
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 99) < 3) trig_sel_i = 2'($urandom_range(0, 3));
            rx_en_i     = ($urandom_range(0, 19) != 0);
            rx_irq_en_i = ($urandom_range(0, 9) != 0);
            step($urandom_range(0, 3) == 0, $urandom_range(0, 255),
                 $urandom_range(0, 4) == 0, $urandom_range(0, 199) == 0,
                 $urandom_range(0, 2) == 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule